// File: doc/BRIEF.md
# Vertical Frame Sequencer for Display Panels

This block steps a display frame through its four vertical phases: visible lines, front porch, sync interval and back porch. It counts line ticks, which are one-cycle strobes from a separate horizontal timing stage. The system clock alone never advances any count. A single 32-bit timing word gives the length of every phase.

A mode input selects how the sync interval behaves. With the mode at 0, the sync output stays high for the whole interval. With the mode at 1, the interval still takes the programmed number of lines, but those lines are dummy lines and no sync pulse is driven.

The timing word and the mode are captured only when a new frame begins. Software can therefore rewrite them at any time, and the change applies from the next frame. Downstream logic follows the frame through these outputs:
- a visible-line flag;
- a line index within the current phase;
- a two-bit phase code;
- a start-of-frame pulse.

Top module: `vframe_gen`

## Requirements
- R1: Timing word bits 9..0 hold the number of visible lines minus one, so the visible phase lasts that value plus one line ticks (1 to 1024).
- R2: Timing word bits 15..10 hold the sync line count minus one, so the sync phase lasts that value plus one line ticks, in either mode.
- R3: Timing word bits 23..16 give the number of front-porch line ticks. A value of zero removes the front-porch phase entirely.
- R4: Timing word bits 31..24 give the number of back-porch line ticks. A value of zero removes the back-porch phase entirely.
- R5: The phase output encodes visible=0, front porch=1, sync=2 and back porch=3. Phases always run in the order 0, 1, 2, 3, then back to 0, leaving out any porch whose length is zero.
- R6: With mode_passive low, vsync is high in every cycle of the sync phase and low in every other cycle.
- R7: With mode_passive high, vsync stays low at all times, and the sync phase still lasts the programmed number of line ticks.
- R8: In a cycle with line_tick low, phase and line_idx keep their values.
- R9: The timing word and mode_passive are captured only on the line tick that enters the visible phase. A change made at any other time affects nothing until the next frame.
- R10: frame_start is high for exactly the one cycle after the line tick that enters the visible phase. vis_active is high exactly while the phase is 0.
- R11: While rst is high (synchronous reset), the sequencer is held at the start of the back-porch phase with line_idx 0, vsync low and frame_start low, and the timing word and mode are captured. After reset, the first back porch lasts the captured back-porch count, or one tick if that count is zero.
- R12: line_idx counts line ticks from 0 within the current phase and returns to 0 on each phase change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_tick | input | 1 | One-cycle strobe marking the end of a line |
| timing_word | input | 32 | Packed lengths of the visible, sync, front-porch and back-porch phases |
| mode_passive | input | 1 | 1 = sync lines are dummy lines with no pulse |
| vsync | output | 1 | Vertical sync level |
| vis_active | output | 1 | High during visible lines |
| line_idx | output | 10 | Zero-based line index within the current phase |
| phase | output | 2 | Current phase code |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The bench builds the block with its default field widths of 10, 6 and 8 bits, which together give the 32-bit timing word. With these widths the test can program every field to its largest value, giving a frame of 1024 visible lines, 64 sync lines and two porches of 255 lines each. The same widths also cover single-line visible and sync phases and porches of zero length. Stimulus mixes a fixed-seed random stream of small frame shapes in both modes with directed cases for these extremes and for rewrites of the timing word in the middle of a frame. The bench checks the measured length of each phase, and each phase output, against a reference model that is updated on every tick.

// File: rtl/vframe_gen.sv
module vframe_gen #(
  parameter int LPS_W   = 10,
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  line_tick,
  input  logic [LPS_W+SYNC_W+2*PORCH_W-1:0]     timing_word,
  input  logic                                  mode_passive,
  output logic                                  vsync,
  output logic                                  vis_active,
  output logic [LPS_W-1:0]                      line_idx,
  output logic [1:0]                            phase,
  output logic                                  frame_start
);
  localparam int SYNC_LO  = LPS_W;
  localparam int FRONT_LO = LPS_W + SYNC_W;
  localparam int BACK_LO  = FRONT_LO + PORCH_W;

  typedef enum logic [1:0] {PH_VIS, PH_FRONT, PH_SYNC, PH_BACK} phase_t;

  phase_t               ph_q, ph_nxt;
  logic [LPS_W-1:0]     cnt_q;
  logic [LPS_W-1:0]     lps_q;
  logic [SYNC_W-1:0]    vsw_q;
  logic [PORCH_W-1:0]   vfp_q, vbp_q;
  logic                 pas_q, fs_q, last_line, enter_vis;

  always_comb begin
    last_line = 1'b0;
    ph_nxt    = ph_q;
    case (ph_q)
      PH_VIS: begin
        last_line = (cnt_q == lps_q);
        ph_nxt    = (vfp_q != '0) ? PH_FRONT : PH_SYNC;
      end
      PH_FRONT: begin
        last_line = (cnt_q + 1'b1 == LPS_W'(vfp_q));
        ph_nxt    = PH_SYNC;
      end
      PH_SYNC: begin
        last_line = (cnt_q == LPS_W'(vsw_q));
        ph_nxt    = (vbp_q != '0) ? PH_BACK : PH_VIS;
      end
      default: begin
        last_line = (vbp_q == '0) || (cnt_q + 1'b1 == LPS_W'(vbp_q));
        ph_nxt    = PH_VIS;
      end
    endcase
  end

  assign enter_vis = line_tick && last_line && (ph_nxt == PH_VIS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_BACK;
      cnt_q <= '0;
      fs_q  <= 1'b0;
      lps_q <= timing_word[LPS_W-1:0];
      vsw_q <= timing_word[SYNC_LO +: SYNC_W];
      vfp_q <= timing_word[FRONT_LO +: PORCH_W];
      vbp_q <= timing_word[BACK_LO +: PORCH_W];
      pas_q <= mode_passive;
    end else begin
      fs_q <= enter_vis;
      if (line_tick) begin
        if (last_line) begin
          ph_q  <= ph_nxt;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (enter_vis) begin
        lps_q <= timing_word[LPS_W-1:0];
        vsw_q <= timing_word[SYNC_LO +: SYNC_W];
        vfp_q <= timing_word[FRONT_LO +: PORCH_W];
        vbp_q <= timing_word[BACK_LO +: PORCH_W];
        pas_q <= mode_passive;
      end
    end
  end

  assign vsync       = (ph_q == PH_SYNC) && !pas_q;
  assign vis_active  = (ph_q == PH_VIS);
  assign line_idx    = cnt_q;
  assign phase       = ph_q;
  assign frame_start = fs_q;
endmodule

// File: rtl/vframe_gen_chk.sv
module vframe_gen_chk #(
  parameter int LPS_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             line_tick,
  input logic             vsync,
  input logic             vis_active,
  input logic [LPS_W-1:0] line_idx,
  input logic [1:0]       phase,
  input logic             frame_start
);
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    !line_tick |=> $stable(phase) && $stable(line_idx)); // R8
  AST_VIS_ORDER: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd0 |=> phase != 2'd3); // R5
  AST_FRONT_ORDER: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd1 |=> phase == 2'd1 || phase == 2'd2); // R5
  AST_SYNC_ORDER: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd2 |=> phase != 2'd1); // R5
  AST_BACK_ORDER: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd3 |=> phase == 2'd3 || phase == 2'd0); // R5
  AST_FRAME_START_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> vis_active && line_idx == '0 && $past(line_tick)); // R10
  AST_FRAME_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start); // R10
  AST_SYNC_IN_SYNC_PHASE: assert property (@(posedge clk) disable iff (rst)
    vsync |-> phase == 2'd2 && !vis_active); // R6
  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (rst)
    phase != $past(phase) |-> line_idx == '0); // R12
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> phase == 2'd3 && line_idx == '0 && !vsync && !frame_start); // R11
endmodule

bind vframe_gen vframe_gen_chk #(.LPS_W(LPS_W)) u_chk (
  .clk(clk), .rst(rst), .line_tick(line_tick), .vsync(vsync),
  .vis_active(vis_active), .line_idx(line_idx), .phase(phase),
  .frame_start(frame_start)
);

// File: tb/vframe_gen_test.sv
`timescale 1ns/1ps
module vframe_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_tick = 1'b0;
  logic [31:0] timing_word = '0;
  logic mode_passive = 1'b0;
  logic vsync, vis_active, frame_start;
  logic [9:0] line_idx;
  logic [1:0] phase;

  int vectors = 0, errors = 0;
  bit done = 0;
  int m_ph, m_cnt, m_lps, m_vsw, m_vfp, m_vbp, run_len;
  bit m_pas, m_fs, midwrite;

  always #10 clk = ~clk;

  vframe_gen uut (
    .clk(clk), .rst(rst), .line_tick(line_tick), .timing_word(timing_word),
    .mode_passive(mode_passive), .vsync(vsync), .vis_active(vis_active),
    .line_idx(line_idx), .phase(phase), .frame_start(frame_start)
  );

  function automatic logic [31:0] pack(int lps, int vsw, int vfp, int vbp);
    return {vbp[7:0], vfp[7:0], vsw[5:0], lps[9:0]};
  endfunction

  function automatic int plen(int ph);
    case (ph)
      0: return m_lps + 1;
      1: return m_vfp;
      2: return m_vsw + 1;
      default: return (m_vbp == 0) ? 1 : m_vbp;
    endcase
  endfunction

  function automatic int pnext(int ph);
    case (ph)
      0: return (m_vfp != 0) ? 1 : 2;
      1: return 2;
      2: return (m_vbp != 0) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic capture();
    m_lps = timing_word[9:0];
    m_vsw = timing_word[15:10];
    m_vfp = timing_word[23:16];
    m_vbp = timing_word[31:24];
    m_pas = mode_passive;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; line_tick = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    m_ph = 3; m_cnt = 0; m_fs = 0; run_len = 0; capture();
    chk(phase == 2'd3, "R11 phase", phase, 3);
    chk(line_idx == 0, "R11 line_idx", line_idx, 0);
    chk(!vsync && !frame_start, "R11 vsync/frame_start", {vsync, frame_start}, 0);
  endtask

  task automatic step(bit t);
    int prev_ph, exp_len, np;
    @(negedge clk);
    line_tick = t;
    prev_ph = m_ph;
    exp_len = plen(m_ph);
    m_fs = 0;
    if (t) begin
      if (m_cnt + 1 >= exp_len) begin
        np = pnext(m_ph);
        if (np == 0) begin m_fs = 1; capture(); end
        m_ph = np; m_cnt = 0;
      end else m_cnt++;
    end
    @(posedge clk); #5;
    chk(phase == m_ph[1:0], t ? "R5 phase" : "R8 phase hold", phase, m_ph);
    chk(line_idx == m_cnt, t ? "R12 line_idx" : "R8 line_idx hold", line_idx, m_cnt);
    chk(vsync == (m_ph == 2 && !m_pas), m_pas ? "R7 vsync" : "R6 vsync", vsync, m_ph == 2 && !m_pas);
    chk(vis_active == (m_ph == 0), "R10 vis_active", vis_active, m_ph == 0);
    chk(frame_start == m_fs, "R10 frame_start", frame_start, m_fs);
    if (t) begin
      run_len++;
      if (phase != prev_ph[1:0]) begin
        case (prev_ph)
          0: chk(run_len == exp_len, midwrite ? "R9 visible length" : "R1 visible length", run_len, exp_len);
          1: chk(run_len == exp_len, "R3 front length", run_len, exp_len);
          2: chk(run_len == exp_len, "R2 sync length", run_len, exp_len);
          default: chk(run_len == exp_len, "R4 back length", run_len, exp_len);
        endcase
        if (prev_ph == 0) midwrite = 0;
        run_len = 0;
      end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      int gap = $urandom % 3;
      for (int g = 0; g < gap; g++) step(1'b0);
      step(1'b1);
    end
  endtask

  initial begin
    int seed_use;
    seed_use = $urandom(32'd2024);
    timing_word = pack(3, 1, 2, 2);
    mode_passive = 1'b0;
    do_reset();
    run(40);

    timing_word = pack(4, 2, 0, 0);
    mode_passive = 1'b1;
    run(40);

    timing_word = pack(5, 0, 1, 1);
    mode_passive = 1'b0;
    run(20);
    while (m_ph != 0) step(1'b1);
    step(1'b1);
    timing_word = pack(1, 3, 3, 0);
    mode_passive = 1'b1;
    midwrite = 1;
    run(40);

    for (int k = 0; k < 8; k++) begin
      timing_word = pack($urandom % 16, $urandom % 8, $urandom % 4, $urandom % 4);
      mode_passive = $urandom % 2;
      run(60);
    end

    timing_word = pack(1023, 63, 255, 255);
    mode_passive = 1'b0;
    run(1700);
    timing_word = pack(0, 0, 0, 0);
    mode_passive = 1'b0;
    run(1700);
    run(10);

    timing_word = pack(0, 0, 0, 0);
    do_reset();
    run(10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule